// File: doc/BRIEF.md
# Interrupt Request Priority Tracker

The tracker watches eight interrupt request lines and decides when the processor should be interrupted. Each line passes through a two-flop synchronizer and then into a pending register. A fixed-priority resolver compares the pending register with an in-service register. Level 0 has the highest priority. A pending level is eligible only when no level of equal or higher priority is in service. The interrupt output is high whenever at least one level is eligible.

The acknowledge sequencer pulses `ackStrobe` at the point where the vector is chosen. The tracker picks the winner at that moment, not when the request first arrived. It moves the winner from pending to in-service and reports the level on `ackLevel`, qualified by `ackValid` one cycle later. If no level is eligible when the strobe arrives, the request has vanished; the tracker then reports level 7 and sets no in-service bit. In-service bits are released in one of two ways:
- automatically, on `ackEnd` (the end of the final acknowledge pulse) when `autoEoi` is high;
- on an end-of-interrupt command, which clears the highest-priority in-service bit.

Top module: `irq_priority_tracker`

## Requirements
- R1: While `rstN` is low and right after it, `intOut` and `ackValid` are 0 and no level is in service.
- R2: A request line held high is visible on `intOut` after the third rising clock edge that samples it: two synchronizer stages plus the pending register.
- R3: Priority is fixed, with level 0 highest. On `ackStrobe` the lowest-numbered eligible level wins and enters service.
- R4: `ackValid` is high for exactly the one cycle after an `ackStrobe` cycle. During that cycle `ackLevel` carries the 3-bit binary level chosen at the strobe.
- R5: A pending level does not raise `intOut` while that level or any lower-numbered level is in service.
- R6: An `ackStrobe` with no eligible level reports level 7 (binary 111) and sets no in-service bit.
- R7: With `autoEoi` high, `ackEnd` clears the in-service bit of the level chosen at the last non-spurious strobe.
- R8: With `autoEoi` low, an in-service bit survives `ackEnd`. A pulse on `eoiCmd` clears the lowest-numbered set in-service bit.
- R9: `intOut` falls in the cycle after the acknowledged level enters service, when no other level is eligible.
- R10: When `ackStrobe` and `eoiCmd` fall in the same cycle, the winner enters service and the end-of-interrupt command clears the highest-priority bit that was in service before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Asynchronous request lines, bit n is level n |
| autoEoi | input | 1 | Selects automatic end-of-interrupt at `ackEnd` |
| ackStrobe | input | 1 | One-cycle pulse: choose winner now |
| ackEnd | input | 1 | One-cycle pulse: final acknowledge pulse finished |
| eoiCmd | input | 1 | One-cycle end-of-interrupt command |
| intOut | output | 1 | Interrupt request to the processor |
| ackValid | output | 1 | `ackLevel` is valid this cycle |
| ackLevel | output | 3 | Level chosen at the last strobe |

## Verification
Two updates to the in-service register can land on the same clock edge: the set caused by an acknowledge and the clear caused by an end-of-interrupt command. The bench provokes this case by first putting level 4 in service. It then raises level 1 and pulses `ackStrobe` and `eoiCmd` together. The result is judged from the ports: the reported level must be 1, and level 5 must later become eligible, which can only happen if level 4 was cleared. A behavioural model, updated on every edge, also judges every cycle of the run.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  typedef struct packed {
    logic latch;   // capture an acknowledge result
    logic setIsr;  // winner enters service
    logic clrEoi;  // clear highest-priority in-service bit
    logic clrAuto; // clear latched level's in-service bit
  } irqtStrobes_t;
endpackage

// File: rtl/irqt_ctrl.sv
module irqt_ctrl
  import irqt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ackStrobe,
  input  logic         ackEnd,
  input  logic         eoiCmd,
  input  logic         autoEoi,
  input  logic         anyEligible,
  output irqtStrobes_t strobes,
  output logic         ackValid
);
  logic realAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      realAck  <= 1'b0;
      ackValid <= 1'b0;
    end else begin
      ackValid <= ackStrobe;
      if (ackStrobe) realAck <= anyEligible;
    end
  end

  always_comb begin
    strobes.latch   = ackStrobe;
    strobes.setIsr  = ackStrobe & anyEligible;
    strobes.clrEoi  = eoiCmd;
    strobes.clrAuto = ackEnd & autoEoi & realAck;
  end
endmodule

// File: rtl/irqt_datapath.sv
module irqt_datapath
  import irqt_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int LEVEL_W    = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] irqIn,
  input  irqtStrobes_t          strobes,
  output logic                  anyEligible,
  output logic [LEVEL_W-1:0]    ackLevel
);
  localparam logic [LEVEL_W-1:0] SPUR_LEVEL = LEVEL_W'(NUM_LEVELS - 1);
  localparam logic [NUM_LEVELS-1:0] ONE_BIT = NUM_LEVELS'(1);

  logic [NUM_LEVELS-1:0] syncA, syncB, pend, isr;
  logic [NUM_LEVELS-1:0] eligible, winMask, eoiMask, autoMask;
  logic [LEVEL_W-1:0]    winIdx, latLevel;

  function automatic logic [LEVEL_W-1:0] firstIdx(input logic [NUM_LEVELS-1:0] v);
    firstIdx = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--)
      if (v[i]) firstIdx = LEVEL_W'(i);
  endfunction

  // a level is blocked by any in-service level of equal or higher priority
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gElig
    assign eligible[g] = pend[g] & ~(|isr[g:0]);
  end

  assign anyEligible = |eligible;
  assign winMask     = eligible & (~eligible + ONE_BIT);
  assign winIdx      = firstIdx(eligible);
  assign eoiMask     = isr & (~isr + ONE_BIT);
  assign autoMask    = ONE_BIT << latLevel;
  assign ackLevel    = latLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      pend     <= '0;
      isr      <= '0;
      latLevel <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
      pend  <= syncB & ~(strobes.setIsr ? winMask : '0);
      isr   <= (isr & ~(strobes.clrEoi ? eoiMask : '0)
                    & ~(strobes.clrAuto ? autoMask : '0))
               | (strobes.setIsr ? winMask : '0);
      if (strobes.latch) latLevel <= strobes.setIsr ? winIdx : SPUR_LEVEL;
    end
  end
endmodule

// File: rtl/irq_priority_tracker.sv
module irq_priority_tracker
  import irqt_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int LEVEL_W    = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] irqIn,
  input  logic                  autoEoi,
  input  logic                  ackStrobe,
  input  logic                  ackEnd,
  input  logic                  eoiCmd,
  output logic                  intOut,
  output logic                  ackValid,
  output logic [LEVEL_W-1:0]    ackLevel
);
  irqtStrobes_t strobes;
  logic         anyEligible;

  irqt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .ackEnd(ackEnd),
    .eoiCmd(eoiCmd), .autoEoi(autoEoi), .anyEligible(anyEligible),
    .strobes(strobes), .ackValid(ackValid)
  );

  irqt_datapath #(.NUM_LEVELS(NUM_LEVELS), .LEVEL_W(LEVEL_W)) uData (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobes(strobes),
    .anyEligible(anyEligible), .ackLevel(ackLevel)
  );

  assign intOut = anyEligible;
endmodule

// File: rtl/irqt_checker.sv
module irqt_checker #(
  parameter int LEVEL_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               ackStrobe,
  input logic               intOut,
  input logic               ackValid,
  input logic [LEVEL_W-1:0] ackLevel
);
  always_comb begin
    if (!rstN) assert_quiet_in_reset_R1: assert (!ackValid) else $error("ackValid during reset");
  end

  assert_valid_follows_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> ackValid);

  assert_valid_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(ackStrobe));

  assert_spurious_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !intOut) |=> (ackLevel == {LEVEL_W{1'b1}}));

  assert_real_needs_request_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && intOut) |=> ackValid);
endmodule

bind irq_priority_tracker irqt_checker #(.LEVEL_W(LEVEL_W)) uChecker (
  .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .intOut(intOut),
  .ackValid(ackValid), .ackLevel(ackLevel)
);

// File: tb/irq_priority_tracker_test.sv
`timescale 1ns/1ps
module irq_priority_tracker_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       autoEoi = 1'b0, ackStrobe = 1'b0, ackEnd = 1'b0, eoiCmd = 1'b0;
  logic       intOut, ackValid;
  logic [2:0] ackLevel;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_priority_tracker uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .autoEoi(autoEoi),
    .ackStrobe(ackStrobe), .ackEnd(ackEnd), .eoiCmd(eoiCmd),
    .intOut(intOut), .ackValid(ackValid), .ackLevel(ackLevel)
  );

  // behavioural reference
  logic [7:0] m1 = '0, m2 = '0, mPend = '0, mIsr = '0;
  int  mLvl = 0;
  bit  mValid = 0, mReal = 0;

  function automatic int bestLevel(input logic [7:0] p, input logic [7:0] s);
    for (int i = 0; i < 8; i++) begin
      if (s[i]) return -1;
      if (p[i]) return i;
    end
    return -1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= '0; m2 <= '0; mPend <= '0; mIsr <= '0;
      mLvl <= 0; mValid <= 0; mReal <= 0;
    end else begin
      int w, e;
      logic [7:0] nIsr, nPend;
      w = bestLevel(mPend, mIsr);
      e = -1;
      for (int i = 7; i >= 0; i--) if (mIsr[i]) e = i;
      nIsr  = mIsr;
      nPend = m2;
      if (eoiCmd && e >= 0) nIsr[e] = 1'b0;
      if (ackEnd && autoEoi && mReal) nIsr[mLvl] = 1'b0;
      if (ackStrobe && w >= 0) begin
        nIsr[w]  = 1'b1;
        nPend[w] = 1'b0;
      end
      if (ackStrobe) begin
        mLvl  <= (w >= 0) ? w : 7;
        mReal <= (w >= 0);
      end
      mValid <= ackStrobe;
      mIsr   <= nIsr;
      mPend  <= nPend;
      m2     <= m1;
      m1     <= irqIn;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2/R5/R9 model intOut", int'(intOut), int'(bestLevel(mPend, mIsr) >= 0));
      check("R4 model ackValid", int'(ackValid), int'(mValid));
      if (mValid) check("R3/R6 model ackLevel", int'(ackLevel), mLvl);
    end
  end

  task automatic setIrq(input logic [7:0] v);
    @(negedge clk); #2 irqIn = v;
  endtask
  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse(input bit a, input bit en, input bit eo);
    @(negedge clk); #2 ackStrobe = a; ackEnd = en; eoiCmd = eo;
    @(negedge clk); #2 ackStrobe = 0; ackEnd = 0; eoiCmd = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    waitN(3);
    check("R1 intOut in reset", int'(intOut), 0);
    check("R1 ackValid in reset", int'(ackValid), 0);
    #2 rstN = 1'b1;
    waitN(2);
    check("R1 intOut after reset", int'(intOut), 0);

    // R2 latency, then R3 priority between levels 2 and 5
    setIrq(8'h24);
    @(negedge clk); check("R2 first edge", int'(intOut), 0);
    @(negedge clk); check("R2 second edge", int'(intOut), 0);
    @(negedge clk); check("R2 third edge", int'(intOut), 1);
    pulse(1, 0, 0);
    check("R4 ackValid", int'(ackValid), 1);
    check("R3 winner level 2", int'(ackLevel), 2);
    check("R5 level 5 blocked by 2", int'(intOut), 0);
    pulse(0, 1, 0);
    check("R4 ackValid one cycle", int'(ackValid), 0);
    check("R8 isr survives ackEnd", int'(intOut), 0);
    setIrq(8'h20); waitN(4);
    pulse(0, 0, 1);
    check("R8 eoi releases level 5", int'(intOut), 1);
    pulse(1, 0, 0);
    check("R3 winner level 5", int'(ackLevel), 5);
    check("R9 intOut drops", int'(intOut), 0);

    // R6 spurious acknowledge
    setIrq(8'h00); waitN(4);
    pulse(1, 0, 0);
    check("R6 spurious level", int'(ackLevel), 7);
    pulse(0, 0, 1);
    setIrq(8'h80); waitN(3);
    check("R6 no isr from spurious", int'(intOut), 1);
    pulse(1, 0, 0);
    check("R3 winner level 7", int'(ackLevel), 7);
    pulse(0, 0, 1);
    setIrq(8'h00); waitN(4);

    // R7 automatic end of interrupt
    @(negedge clk); #2 autoEoi = 1'b1;
    setIrq(8'h08); waitN(3);
    pulse(1, 0, 0);
    check("R3 winner level 3", int'(ackLevel), 3);
    check("R7 self blocked before end", int'(intOut), 0);
    pulse(0, 1, 0);
    check("R7 auto clear at ackEnd", int'(intOut), 1);
    pulse(1, 0, 0);
    setIrq(8'h00);
    pulse(0, 1, 0);
    @(negedge clk); #2 autoEoi = 1'b0;
    waitN(4);

    // R10 acknowledge and eoi in the same cycle
    setIrq(8'h10); waitN(3);
    pulse(1, 0, 0);
    check("R3 winner level 4", int'(ackLevel), 4);
    setIrq(8'h12); waitN(3);
    check("R5 level 1 preempts 4", int'(intOut), 1);
    pulse(1, 0, 1);
    check("R10 winner level 1", int'(ackLevel), 1);
    setIrq(8'h00); waitN(4);
    pulse(0, 0, 1);
    setIrq(8'h20); waitN(3);
    check("R10 level 4 was cleared", int'(intOut), 1);
    waitN(2);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule